// File: doc/BRIEF.md
# Electronic Dice Face Counter

This block produces the face value of an electronic die. While the roll input is held high, the stored face steps downward by one on every rising clock edge: 6, 5, 4, 3, 2, 1, and then back to 6. The stop point is set by when the roll input is released. The result is a random-looking face drawn from the six faces of a die.

A face of zero is never held in the register, even for a moment. When the count stands at 1 and another step is taken, the same clock edge loads 6. This reload is synchronous, so no decoded zero ever drives a preset line. A synchronous active-low reset loads the starting face, 6.

The face is given in two forms. One is a 3-bit binary value. The other is a one-hot group of six lines, one line per face, so a display with one lamp per face can use it directly.

Top module: `dice_roller`

## Requirements
- R1: On a rising edge with `rst_n` low, the face is loaded with 6. After that edge, `face` reads 3'b110 and `face_onehot` reads 6'b100000.
- R2: On a rising edge with `rst_n` high, `roll_en` high and a face of 2 to 6, the face drops by exactly one.
- R3: On a rising edge with `rst_n` high, `roll_en` high and a face of 1, the face becomes 6. No intermediate zero appears on `face` in any cycle.
- R4: On a rising edge with `rst_n` high and `roll_en` low, the face keeps its value.
- R5: Out of reset, `face` always lies between 1 and 6. The codes 3'b000 and 3'b111 never appear.
- R6: `face_onehot` has exactly one line high. Bit k (k = 0 to 5) is high exactly when `face` equals k+1.
- R7: Reset takes priority over rolling: an edge with `rst_n` low loads 6 even when `roll_en` is high.
- R8: With `roll_en` held high from the starting face, successive edges give 5, 4, 3, 2, 1, 6 and then repeat with a period of six edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; loads face 6 |
| roll_en | input | 1 | High to step the face downward once per edge |
| face | output | 3 | Current face as a binary value, 1 to 6 |
| face_onehot | output | 6 | Current face as one line per face; bit k means face k+1 |

## Verification
The bench rolls through many full cycles of the sequence with roll bursts of varied length. This hits the wrap from 1 to 6 with the enable both held and freshly raised. A design that decrements blindly would show 0 there, and a two-step reload would show 0 for one cycle.

Hold stretches of several lengths check that a low enable freezes the face, rather than letting it drift or reload. Resets applied mid-roll with the enable still high check that reset wins and that the reloaded face is 6, not 0 or the wrapped value.

Every cycle also compares the one-hot lines against the binary face. This catches an off-by-one line mapping or two lines active at once.

// File: rtl/dice_pkg.sv
// Package: dice_pkg
// Shared defaults and the step classification used between the next-state
// classifier and the face register. Assumes nothing about the clock domain.
package dice_pkg;

    localparam int DICE_FACE_W_DEF   = 3;
    localparam int DICE_FACE_MAX_DEF = 6;
    localparam int DICE_FACE_MIN_DEF = 1;

    // What the face register does at the next enabled edge.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_DOWN = 2'd1,
        STEP_WRAP = 2'd2
    } dice_step_e;

endpackage

// File: rtl/dice_step_sel.sv
// Module: dice_step_sel
// Classifies the next step of the face register from the current face and
// the roll enable: hold, step down by one, or wrap back to the top face.
// Assumes the current face always lies in [FACE_MIN, FACE_MAX].
module dice_step_sel
    import dice_pkg::*;
#(
    parameter int FACE_W   = DICE_FACE_W_DEF,
    parameter int FACE_MAX = DICE_FACE_MAX_DEF,
    parameter int FACE_MIN = DICE_FACE_MIN_DEF
) (
    input  logic [FACE_W-1:0] cur_face,
    input  logic              roll_en,
    output dice_step_e        step
);

    localparam logic [FACE_W-1:0] LOW_FACE = FACE_W'(FACE_MIN);

    // Pick the step kind; the bottom face wraps instead of decrementing.
    always_comb begin
        if (!roll_en) begin
            step = STEP_HOLD;
        end else if (cur_face == LOW_FACE) begin
            step = STEP_WRAP;
        end else begin
            step = STEP_DOWN;
        end
    end

endmodule

// File: rtl/dice_face_reg.sv
// Module: dice_face_reg
// Holds the current face. A synchronous active-low reset loads the top face;
// otherwise the register applies the step chosen by dice_step_sel. The wrap
// loads the top face in one edge, so no zero state is ever stored.
// Assumes rst_n is synchronous to clk.
module dice_face_reg
    import dice_pkg::*;
#(
    parameter int FACE_W   = DICE_FACE_W_DEF,
    parameter int FACE_MAX = DICE_FACE_MAX_DEF,
    parameter int FACE_MIN = DICE_FACE_MIN_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              roll_en,
    input  dice_step_e        step,
    output logic [FACE_W-1:0] face_q
);

    localparam logic [FACE_W-1:0] TOP_FACE = FACE_W'(FACE_MAX);
    localparam logic [FACE_W-1:0] LOW_FACE = FACE_W'(FACE_MIN);
    localparam logic [FACE_W-1:0] ONE      = FACE_W'(1);

    // Face register update: reset first, then the selected step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            face_q <= TOP_FACE;
        end else begin
            case (step)
                STEP_DOWN: face_q <= face_q - ONE;
                STEP_WRAP: face_q <= TOP_FACE;
                default:   face_q <= face_q;
            endcase
        end
    end

    // Leaving reset, the register holds the top face.
    assert_reset_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> face_q == TOP_FACE);

    // An enabled step above the bottom face lowers the face by one.
    assert_step_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_en && face_q != LOW_FACE) |=> face_q == $past(face_q) - ONE);

    // An enabled step at the bottom face lands on the top face directly.
    assert_wrap_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_en && face_q == LOW_FACE) |=> face_q == TOP_FACE);

    // A low enable freezes the face.
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !roll_en |=> $stable(face_q));

    // Face never shows zero or a value above the top face.
    assert_face_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        face_q >= LOW_FACE && face_q <= TOP_FACE);

endmodule

// File: rtl/dice_onehot_dec.sv
// Module: dice_onehot_dec
// Decodes the binary face into one line per face; line k is high for face k+1.
// Assumes the face lies in [1, FACE_MAX]; out-of-range codes give all zeros.
module dice_onehot_dec
    import dice_pkg::*;
#(
    parameter int FACE_W   = DICE_FACE_W_DEF,
    parameter int FACE_MAX = DICE_FACE_MAX_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [FACE_W-1:0]   face,
    output logic [FACE_MAX-1:0] lines
);

    localparam logic [FACE_W-1:0] ONE = FACE_W'(1);

    // One comparator per face line.
    for (genvar k = 0; k < FACE_MAX; k++) begin : g_line
        assign lines[k] = (face == FACE_W'(k + 1));
    end

    // Exactly one line high, and it is the one that matches the binary face.
    assert_onehot_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lines) == 1 && lines[face - ONE]);

endmodule

// File: rtl/dice_roller.sv
// Module: dice_roller
// Electronic dice face counter: steps the face down from the top face to 1
// while roll_en is high, reloading the top face in place of zero, and gives
// the face both in binary and as one line per face.
// Assumes a single clock and a reset synchronous to it.
module dice_roller
    import dice_pkg::*;
#(
    parameter int FACE_W   = DICE_FACE_W_DEF,
    parameter int FACE_MAX = DICE_FACE_MAX_DEF,
    parameter int FACE_MIN = DICE_FACE_MIN_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                roll_en,
    output logic [FACE_W-1:0]   face,
    output logic [FACE_MAX-1:0] face_onehot
);

    dice_step_e        step;
    logic [FACE_W-1:0] face_q;

    dice_step_sel #(
        .FACE_W  (FACE_W),
        .FACE_MAX(FACE_MAX),
        .FACE_MIN(FACE_MIN)
    ) u_step (
        .cur_face(face_q),
        .roll_en (roll_en),
        .step    (step)
    );

    dice_face_reg #(
        .FACE_W  (FACE_W),
        .FACE_MAX(FACE_MAX),
        .FACE_MIN(FACE_MIN)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .roll_en(roll_en),
        .step   (step),
        .face_q (face_q)
    );

    dice_onehot_dec #(
        .FACE_W  (FACE_W),
        .FACE_MAX(FACE_MAX)
    ) u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .face (face_q),
        .lines(face_onehot)
    );

    assign face = face_q;

    // Reset wins over an active roll enable.
    assert_reset_priority_R7: assert property (@(posedge clk)
        (!rst_n && roll_en) |=> face == FACE_W'(FACE_MAX));

endmodule

// File: tb/dice_roller_tb.sv
// Bench for dice_roller: drives reset and roll patterns, models the expected
// face arithmetically and compares both outputs every cycle.
module dice_roller_tb;

    localparam int W    = 3;
    localparam int MAXF = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            roll_en = 1'b0;
    logic [W-1:0]    face;
    logic [MAXF-1:0] face_onehot;

    int checks = 0;
    int failures = 0;
    int exp_face = MAXF;
    bit finished = 0;

    always #10 clk = ~clk;

    dice_roller u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .roll_en    (roll_en),
        .face       (face),
        .face_onehot(face_onehot)
    );

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // One clock: drive at negedge, model the edge, sample 1 ns after it.
    task automatic cycle(input logic r, input logic en, input string tag);
        int prev;
        @(negedge clk);
        rst_n   = r;
        roll_en = en;
        prev = exp_face;
        if (!r)                exp_face = MAXF;
        else if (en && prev == 1) exp_face = MAXF;
        else if (en)           exp_face = prev - 1;
        @(posedge clk);
        #1;
        check(tag, int'(face), exp_face);
        check("R5 range", int'(face >= 1 && face <= MAXF), 1);
        check("R6 onehot", int'(face_onehot), 1 << (exp_face - 1));
    endtask

    initial begin
        // R1: reset loads 6.
        cycle(1'b0, 1'b0, "R1 reset");
        cycle(1'b0, 1'b0, "R1 reset");
        check("R1 binary", int'(face), 6);
        check("R1 onehot", int'(face_onehot), 32);
        // R8: full sequence from start with enable held.
        begin
            int seq [12] = '{5, 4, 3, 2, 1, 6, 5, 4, 3, 2, 1, 6};
            for (int i = 0; i < 12; i++) begin
                cycle(1'b1, 1'b1, (exp_face == 1) ? "R3 wrap" : "R2 step");
                check("R8 sequence", int'(face), seq[i]);
            end
        end
        // R4: hold at every face, various lengths.
        for (int f = 0; f < 6; f++) begin
            for (int h = 0; h <= f; h++) cycle(1'b1, 1'b0, "R4 hold");
            cycle(1'b1, 1'b1, (exp_face == 1) ? "R3 wrap" : "R2 step");
        end
        // Mixed roll bursts, wrap with freshly raised enable.
        for (int i = 0; i < 300; i++) begin
            logic en;
            en = ((i % 7) < 4) || ((i % 5) == 0);
            if (en) cycle(1'b1, 1'b1, (exp_face == 1) ? "R3 wrap" : "R2 step");
            else    cycle(1'b1, 1'b0, "R4 hold");
        end
        // R7: reset mid-roll at each face, enable high.
        for (int f = 0; f < 6; f++) begin
            for (int s = 0; s < f; s++) cycle(1'b1, 1'b1, (exp_face == 1) ? "R3 wrap" : "R2 step");
            cycle(1'b0, 1'b1, "R7 reset priority");
            check("R7 face", int'(face), 6);
        end
        cycle(1'b1, 1'b1, "R2 step");
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule